// File: doc/BRIEF.md
# Successive-Approximation Conversion Sequencer

This block is the digital controller of a successive-approximation analog-to-digital converter. A single-cycle `go` pulse starts a conversion. The block raises `hold` so that the external sample/hold stage freezes the analog input. It then works through the result one bit at a time, starting at the top bit. For each bit it places a candidate code on `trial_code`, which feeds an external DAC. It waits a fixed, parameterised number of cycles for the DAC and the comparator to settle, and then reads the one-bit comparator answer.

The comparator answer is asynchronous to the clock, so it passes through a two-flop synchroniser. The settle count must cover those two cycles of latency. After the last bit the block drops `hold`, puts the code on `result` and pulses `done` for one cycle. The conversion always takes the same number of cycles, whatever the input level.

Top module: `sar_sequencer`

## Requirements
- R1: While reset is low, and in the first cycle after reset, `hold`, `done`, `trial_code` and `result` are all 0.
- R2: A `go` high seen at a clock edge while idle starts a conversion. From that edge on, `hold` is 1 and `trial_code` has only bit WIDTH-1 set.
- R3: Bits are tried from bit WIDTH-1 down to bit 0. Each trial sets the bit under test to 1 on top of the bits already decided. Each trial code is held for exactly SETTLE cycles.
- R4: The bit under test stays 1 only when the synchronised comparator input is 1. A comparator input of 1 means the DAC output is at or below the held input. Otherwise the bit is cleared.
- R5: `done` rises exactly WIDTH*SETTLE clock edges after the edge that accepted `go`, for every input level.
- R6: `done` is high for a single cycle. `hold` falls on the same edge on which `done` rises, and stays low until the next accepted `go`.
- R7: `result` changes only on the edge that raises `done`. It then keeps its value until the next conversion completes.
- R8: A `go` pulse that arrives while a conversion is running has no effect. The running conversion keeps its timing, its trial codes and its result.
- R9: With an ideal DAC and comparator closing the loop, the result equals the input level in LSBs, rounded down, for every level from 0 to 2^WIDTH-1.
- R10: The comparator input reaches the decision through two flip-flops. SETTLE must be at least 3, so that each decision sees the answer to the trial code currently driven.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| go | input | 1 | Start pulse; honoured only while idle |
| cmp_in | input | 1 | Comparator answer, asynchronous; 1 when DAC output is at or below the held input |
| trial_code | output | WIDTH | Candidate code driven to the external DAC |
| hold | output | 1 | Sample/hold control, high for the whole conversion |
| result | output | WIDTH | Converted code, updated when `done` pulses |
| done | output | 1 | One-cycle completion pulse |

## Verification
The assertions assume that reset is held low for at least one clock edge. They also assume that `cmp_in` answers the code currently on `trial_code` within the synchroniser window: it may change only after a new trial code appears and must settle before the next decision edge. The bench meets both assumptions. It models the DAC and comparator as an instant comparison of the trial code against a fixed input level, and it changes that level only while the block is idle. It also drives `go` only on falling edges, as single-cycle pulses, and sends a stray pulse during each conversion to exercise the rule that such pulses are ignored.

// File: rtl/sar_seq_pkg.sv
package sar_seq_pkg;

  typedef enum logic [0:0] {
    ST_IDLE = 1'b0,
    ST_CONV = 1'b1
  } sar_state_e;

  // Clear the bit under test when the comparator rejects it.
  function automatic logic [31:0] sar_settle_bit(logic [31:0] code,
                                                 int unsigned idx,
                                                 logic keep);
    logic [31:0] r;
    r = code;
    if (!keep) r[idx] = 1'b0;
    return r;
  endfunction

  // Decide the current bit, then raise the next lower one as the new trial.
  function automatic logic [31:0] sar_trial_next(logic [31:0] code,
                                                 int unsigned idx,
                                                 logic keep);
    logic [31:0] r;
    r = sar_settle_bit(code, idx, keep);
    if (idx != 0) r[idx-1] = 1'b1;
    return r;
  endfunction

endpackage

// File: rtl/sar_cmp_sync.sv
module sar_cmp_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic async_in,
  output logic sync_out
);
  logic [STAGES-1:0] chain;

  genvar g;
  generate
    for (g = 0; g < STAGES; g++) begin : g_stage
      if (g == 0) begin : g_first
        always_ff @(posedge clk) begin
          if (!rst_n) chain[0] <= 1'b0;
          else        chain[0] <= async_in;
        end
      end else begin : g_rest
        always_ff @(posedge clk) begin
          if (!rst_n) chain[g] <= 1'b0;
          else        chain[g] <= chain[g-1];
        end
      end
    end
  endgenerate

  assign sync_out = chain[STAGES-1];
endmodule

// File: rtl/sar_settle_timer.sv
module sar_settle_timer #(
  parameter int SETTLE = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic restart,
  input  logic run,
  output logic expire
);
  localparam int CW = $clog2(SETTLE + 1);
  localparam logic [CW-1:0] LAST = CW'(SETTLE - 1);

  logic [CW-1:0] cnt;

  always_ff @(posedge clk) begin
    if (!rst_n)              cnt <= '0;
    else if (restart)        cnt <= '0;
    else if (run) begin
      if (cnt == LAST)       cnt <= '0;
      else                   cnt <= cnt + 1'b1;
    end
  end

  assign expire = run && (cnt == LAST);

  // R3
  settle_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cnt <= LAST);

  // R3
  settle_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    expire && !restart |=> cnt == '0);
endmodule

// File: rtl/sar_code_reg.sv
module sar_code_reg
  import sar_seq_pkg::*;
#(
  parameter int WIDTH = 8,
  parameter int IDXW  = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic             step,
  input  logic             keep,
  output logic [WIDTH-1:0] code,
  output logic [WIDTH-1:0] decided,
  output logic             last
);
  localparam logic [WIDTH-1:0] MSB_ONLY = WIDTH'(1) << (WIDTH - 1);

  logic [IDXW-1:0] idx;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      code <= '0;
      idx  <= '0;
    end else if (load) begin
      code <= MSB_ONLY;
      idx  <= IDXW'(WIDTH - 1);
    end else if (step) begin
      code <= WIDTH'(sar_trial_next(32'(code), 32'(idx), keep));
      if (idx != '0) idx <= idx - 1'b1;
    end
  end

  assign decided = WIDTH'(sar_settle_bit(32'(code), 32'(idx), keep));
  assign last    = (idx == '0);

  // R3
  step_order_chk: assert property (@(posedge clk) disable iff (!rst_n)
    step && !load && !last |=> idx == $past(idx) - 1'b1);

  // R4
  keep_bit_chk: assert property (@(posedge clk) disable iff (!rst_n)
    step && !load && keep |=> code[$past(idx)]);

  // R4
  drop_bit_chk: assert property (@(posedge clk) disable iff (!rst_n)
    step && !load && !keep |=> !code[$past(idx)]);
endmodule

// File: rtl/sar_sequencer.sv
module sar_sequencer
  import sar_seq_pkg::*;
#(
  parameter int WIDTH       = 8,
  parameter int SETTLE      = 4,
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             go,
  input  logic             cmp_in,
  output logic [WIDTH-1:0] trial_code,
  output logic             hold,
  output logic [WIDTH-1:0] result,
  output logic             done
);
  localparam int IDXW = (WIDTH > 1) ? $clog2(WIDTH) : 1;

  sar_state_e       state;
  logic             cmp_sync;
  logic             timer_expire;
  logic             start_w;
  logic             step_fire;
  logic             finish_w;
  logic             last_bit;
  logic [WIDTH-1:0] decided_w;

  assign start_w   = (state == ST_IDLE) && go;
  assign step_fire = (state == ST_CONV) && timer_expire;
  assign finish_w  = step_fire && last_bit;

  sar_cmp_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk      (clk),
    .rst_n    (rst_n),
    .async_in (cmp_in),
    .sync_out (cmp_sync)
  );

  sar_settle_timer #(.SETTLE(SETTLE)) u_timer (
    .clk     (clk),
    .rst_n   (rst_n),
    .restart (start_w),
    .run     (state == ST_CONV),
    .expire  (timer_expire)
  );

  sar_code_reg #(.WIDTH(WIDTH), .IDXW(IDXW)) u_code (
    .clk     (clk),
    .rst_n   (rst_n),
    .load    (start_w),
    .step    (step_fire),
    .keep    (cmp_sync),
    .code    (trial_code),
    .decided (decided_w),
    .last    (last_bit)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state  <= ST_IDLE;
      hold   <= 1'b0;
      done   <= 1'b0;
      result <= '0;
    end else begin
      done <= finish_w;
      if (start_w) begin
        state <= ST_CONV;
        hold  <= 1'b1;
      end else if (finish_w) begin
        state  <= ST_IDLE;
        hold   <= 1'b0;
        result <= decided_w;
      end
    end
  end

  // R10
  initial begin : settle_param_chk
    assert (SETTLE >= SYNC_STAGES + 1)
      else $error("SETTLE must exceed the synchroniser depth");
  end

  // R6
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  // R6
  hold_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(hold) |-> done);

  // R6
  done_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !hold);

  // R7
  result_steady_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(result) |-> done);

  // R8
  go_ignored_chk: assert property (@(posedge clk) disable iff (!rst_n)
    hold && go && !finish_w |=> hold && !$rose(trial_code[WIDTH-1]));

  // R2
  start_code_chk: assert property (@(posedge clk) disable iff (!rst_n)
    start_w |=> hold && trial_code == (WIDTH'(1) << (WIDTH - 1)));

  // R3
  code_moves_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(trial_code) |-> $past(start_w || step_fire));
endmodule

// File: tb/sar_sequencer_test.sv
module sar_sequencer_test;
  localparam int W = 8;
  localparam int S = 4;
  localparam int CONV = W * S;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         go = 1'b0;
  logic         cmp_in;
  logic [W-1:0] trial_code;
  logic         hold;
  logic [W-1:0] result;
  logic         done;

  int errors = 0;
  int checks = 0;
  int vin_q  = 0;   // input level in quarter-LSB units

  always #4 clk = ~clk;  // 125 MHz

  // ideal DAC + comparator: 1 when DAC level is at or below the input
  assign cmp_in = (int'(trial_code) * 4 <= vin_q);

  sar_sequencer #(.WIDTH(W), .SETTLE(S)) uut (
    .clk(clk), .rst_n(rst_n), .go(go), .cmp_in(cmp_in),
    .trial_code(trial_code), .hold(hold), .result(result), .done(done)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
    end
  endtask

  // expected trial code after m completed decisions of value flr
  function automatic int exp_trial(int flr, int m);
    if (m >= W) return flr;
    return ((flr >> (W - m)) << (W - m)) | (1 << (W - 1 - m));
  endfunction

  task automatic convert(input int level_q, input int prev);
    int flr;
    flr = level_q / 4;
    vin_q = level_q;
    @(negedge clk);
    go = 1'b1;
    @(posedge clk);
    for (int j = 0; j <= CONV; j++) begin
      @(negedge clk);
      go = (j == 5);  // stray pulse mid-conversion (R8)
      if (j == 0) chk(trial_code == W'(1 << (W-1)), "R2 first trial", trial_code, 1 << (W-1));
      if (j < CONV) begin
        chk(hold == 1'b1, "R2 hold high", hold, 1);
        chk(done == 1'b0, "R5 done early", done, 0);
        chk(int'(trial_code) == exp_trial(flr, j / S), "R3 trial code", trial_code, exp_trial(flr, j / S));
        chk(int'(result) == prev, "R7 result steady", result, prev);
        if (j > 5) chk(int'(trial_code) == exp_trial(flr, j / S), "R8 stray go", trial_code, exp_trial(flr, j / S));
      end else begin
        chk(done == 1'b1, "R5 done timing", done, 1);
        chk(hold == 1'b0, "R6 hold falls", hold, 0);
        chk(int'(result) == flr, "R9 floor result", result, flr);
        chk(int'(trial_code) == flr, "R4 final code", trial_code, flr);
      end
    end
    go = 1'b0;
    for (int k = 0; k < 3; k++) begin
      @(negedge clk);
      chk(done == 1'b0, "R6 single pulse", done, 0);
      chk(hold == 1'b0, "R6 hold low", hold, 0);
      chk(int'(result) == flr, "R7 result kept", result, flr);
    end
  endtask

  initial begin : watchdog
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    $display("  Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin : main
    int prev;
    repeat (3) @(negedge clk);
    chk(hold == 1'b0 && done == 1'b0, "R1 reset ctrl", {hold, done}, 0);
    chk(trial_code == '0 && result == '0, "R1 reset data", trial_code, 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk(hold == 1'b0 && done == 1'b0 && result == '0, "R1 after reset", result, 0);
    // R10: comparator answer used only after two sync flops (covered by per-step trial checks)
    prev = 0;
    for (int lvl = 0; lvl < (1 << W); lvl++) begin
      convert(lvl * 4 + (lvl % 4), prev);
      prev = lvl;
    end
    convert(4 * ((1 << W) - 1) + 3, prev);  // top of range
    convert(0, (1 << W) - 1);                // back to bottom
    $display("  Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule